// File: doc/BRIEF.md
# Valid-Qualified Trigger Capture Path

This block carries a trigger event from its sources to a sample capture engine whose sample strobe comes from a decimator. At a high decimation ratio the strobe may pulse only once every several clocks. A trigger that fires between strobes must not vanish. The block therefore keeps a fired trigger pending until the next sample strobe and attributes it to that sample. Two sources feed it: an internal request that is already in the clock domain, and an external pin. The pin is synchronised, and only its rising edge counts as a trigger.

The qualified trigger is then delayed by a number of samples, not clocks, so it stays aligned with a data path that is delayed by the same number of samples. A short fixed clock delay follows, which matches data that takes a side path of fixed latency into capture. A separate output, one register behind the held trigger, gives a low-latency copy for cascading into a neighbouring trigger unit.

Two small state machines carry the control. The edge detector has states EDGE_LOW and EDGE_HIGH; it moves EDGE_LOW to EDGE_HIGH when the synchronised pin reads 1, and EDGE_HIGH to EDGE_LOW when it reads 0. The hold machine has states HOLD_IDLE and HOLD_PEND. It moves HOLD_IDLE to HOLD_PEND on a request without a strobe, and HOLD_PEND to HOLD_IDLE on any strobe.

Top module: `trig_capture_path`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, trig_held, trig_cascade, trig_sample and trig_capture are all 0 and no trigger is pending.
- R2: ext_trig_pin passes through SYNC_STAGES flip-flops. A 0-to-1 change of the synchronised level gives an external request for exactly one clock. A pin held at 1 gives no further request.
- R3: A request (internal or external) in a cycle where smp_valid is 0 makes the trigger pending. trig_held stays 1 in every later cycle until a cycle with smp_valid at 1.
- R4: In a cycle where smp_valid is 1, a pending trigger or a current request is consumed as the trigger of that sample. After that cycle, nothing stays pending unless a new request arrives.
- R5: The internal request int_trig and the external edge request are combined by OR. Either one alone triggers; both together count as one trigger.
- R6: trig_sample is 1 exactly when the sample DELAY_SAMPLES strobes before the latest strobe was a trigger sample. It changes only in the clock after a cycle with smp_valid at 1.
- R7: trig_capture equals trig_sample delayed by FIX_CYCLES clocks, whatever smp_valid does.
- R8: trig_cascade equals trig_held delayed by one clock.
- R9: A pin pulse that is high for a single clock, with no strobe near it, still yields exactly one trigger sample at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe from the decimator |
| int_trig | input | 1 | Internal trigger request, synchronous |
| ext_trig_pin | input | 1 | External trigger pin, asynchronous |
| trig_held | output | 1 | Current or pending trigger, held until a strobe |
| trig_cascade | output | 1 | trig_held one clock later, for cascading |
| trig_sample | output | 1 | Trigger delayed by DELAY_SAMPLES samples |
| trig_capture | output | 1 | trig_sample delayed by FIX_CYCLES clocks |

## Verification
The bench builds the block with SYNC_STAGES=2, DELAY_SAMPLES=3 and FIX_CYCLES=3. A sample delay of three, rather than two, lets a distinct trigger sit in every stage at once, so a stage that advances on clocks instead of strobes, or drops a stage, shows up at the output. The strobe period is swept from every clock to once in nine clocks. With that range, single-clock pin pulses, held pin levels and internal requests land both on and between strobes. Sparse strobes are the case where clock counting and sample counting disagree.

// File: rtl/trig_path_pkg.sv
package trig_path_pkg;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;

    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_PEND = 1'b1
    } hold_state_t;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync
    import trig_path_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_s;
    edge_state_t            state_q;
    edge_state_t            state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= pin_async;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign level_s = sync_q[LAST];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (level_s)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!level_s) state_d = EDGE_LOW;
            default:   state_d = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        rise_pulse = 1'b0;
        unique case (state_q)
            EDGE_LOW:  rise_pulse = level_s;
            EDGE_HIGH: rise_pulse = 1'b0;
            default:   rise_pulse = 1'b0;
        endcase
    end

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/trig_hold_fsm.sv
module trig_hold_fsm
    import trig_path_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic req,
    output logic held,
    output logic hit
);

    hold_state_t state_q;
    hold_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_IDLE: if (req && !smp_valid) state_d = HOLD_PEND;
            HOLD_PEND: if (smp_valid)         state_d = HOLD_IDLE;
            default:   state_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        held = 1'b0;
        unique case (state_q)
            HOLD_IDLE: held = req;
            HOLD_PEND: held = 1'b1;
            default:   held = 1'b0;
        endcase
        hit = held && smp_valid;
    end

    // R3
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !smp_valid) |=> (state_q == HOLD_PEND));

    // R3
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == HOLD_PEND) && !smp_valid) |=> held);

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (state_q == HOLD_IDLE));

endmodule

// File: rtl/trig_sample_delay.sv
module trig_sample_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         stage_q[0] <= 1'b0;
                    else if (smp_valid) stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         stage_q[g] <= 1'b0;
                    else if (smp_valid) stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(dout));

endmodule

// File: rtl/trig_fixed_delay.sv
module trig_fixed_delay #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (CYCLES == 0) begin : g_pass
            assign dout = din;
        end else begin : g_pipe
            logic [CYCLES-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= din;
                    for (int i = 1; i < CYCLES; i++) begin
                        pipe_q[i] <= pipe_q[i-1];
                    end
                end
            end
            assign dout = pipe_q[CYCLES-1];
        end
    endgenerate

endmodule

// File: rtl/trig_capture_path.sv
module trig_capture_path #(
    parameter int SYNC_STAGES   = 2,
    parameter int DELAY_SAMPLES = 2,
    parameter int FIX_CYCLES    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic int_trig,
    input  logic ext_trig_pin,
    output logic trig_held,
    output logic trig_cascade,
    output logic trig_sample,
    output logic trig_capture
);

    logic ext_rise;
    logic any_req;
    logic sample_hit;

    trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (ext_trig_pin),
        .rise_pulse (ext_rise)
    );

    assign any_req = int_trig | ext_rise;

    trig_hold_fsm u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .req       (any_req),
        .held      (trig_held),
        .hit       (sample_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_cascade <= 1'b0;
        else        trig_cascade <= trig_held;
    end

    trig_sample_delay #(.DEPTH(DELAY_SAMPLES)) u_sdly (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .din       (sample_hit),
        .dout      (trig_sample)
    );

    trig_fixed_delay #(.CYCLES(FIX_CYCLES)) u_fdly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_sample),
        .dout  (trig_capture)
    );

    // R5
    int_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_trig |-> trig_held);

    // R8
    cascade_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_held |=> trig_cascade);

endmodule

// File: tb/trig_capture_path_test.sv
module trig_capture_path_test;

    localparam int S = 2;
    localparam int D = 3;
    localparam int F = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;
    logic itrg = 1'b0;
    logic pin = 1'b0;
    logic o_held, o_casc, o_samp, o_capt;

    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_capture_path #(
        .SYNC_STAGES(S), .DELAY_SAMPLES(D), .FIX_CYCLES(F)
    ) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(vld), .int_trig(itrg),
        .ext_trig_pin(pin), .trig_held(o_held), .trig_cascade(o_casc),
        .trig_sample(o_samp), .trig_capture(o_capt)
    );

    // behavioural reference
    bit sq[$];
    bit sdq[$];
    bit cq[$];
    bit pend_m;
    bit casc_m;
    bit h_m, hit_m, sd_m;
    int hits_seen;

    function automatic bit m_edge();
        return sq[S-1] && !sq[S];
    endfunction

    function automatic bit m_held();
        return pend_m | itrg | m_edge();
    endfunction

    task automatic m_reset();
        sq = {}; sdq = {}; cq = {};
        for (int i = 0; i <= S; i++) sq.push_back(1'b0);
        for (int i = 0; i < D; i++) sdq.push_back(1'b0);
        for (int i = 0; i < F; i++) cq.push_back(1'b0);
        pend_m = 1'b0;
        casc_m = 1'b0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            h_m   = m_held();
            hit_m = vld & h_m;
            sd_m  = sdq[D-1];
            if (hit_m) hits_seen++;
            pend_m = !vld & h_m;
            casc_m = h_m;
            if (vld) begin
                sdq.push_front(hit_m);
                void'(sdq.pop_back());
            end
            cq.push_front(sd_m);
            void'(cq.pop_back());
            sq.push_front(pin);
            void'(sq.pop_back());
        end
    end

    task automatic check(string tag, bit act, bit exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 R3 R4 R5 R9 trig_held", o_held, m_held());
        check("R8 trig_cascade", o_casc, casc_m);
        check("R6 trig_sample", o_samp, sdq[D-1]);
        check("R7 trig_capture", o_capt, cq[F-1]);
    endtask

    task automatic step(bit v, bit i, bit p);
        @(negedge clk);
        vld = v; itrg = i; pin = p;
        #5;
        compare_all();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        hits_seen = 0;
        m_reset();
        // R1: outputs low in reset, even with requests present
        repeat (3) @(negedge clk);
        vld = 1'b1; itrg = 1'b0; pin = 1'b1;
        #5;
        check("R1 reset trig_held", o_held, 1'b0);
        check("R1 reset trig_cascade", o_casc, 1'b0);
        check("R1 reset trig_sample", o_samp, 1'b0);
        check("R1 reset trig_capture", o_capt, 1'b0);
        @(negedge clk);
        vld = 1'b0; pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R1 post-reset trig_held", o_held, 1'b0);
        check("R1 post-reset trig_sample", o_samp, 1'b0);

        // R9: single-clock pin pulse far from any strobe
        begin
            int h0;
            h0 = hits_seen;
            step(1'b0, 1'b0, 1'b1);
            for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            check("R9 one trigger sample from short pulse", (hits_seen - h0) == 1, 1'b1);
        end

        // R2: held pin level gives one request only
        begin
            int h0;
            h0 = hits_seen;
            for (int k = 0; k < 20; k++) step(k % 3 == 0, 1'b0, 1'b1);
            for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0);
            check("R2 one trigger from held pin", (hits_seen - h0) == 1, 1'b1);
        end

        // R5: internal and external together count once
        begin
            int h0;
            h0 = hits_seen;
            step(1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b1, 1'b1);
            step(1'b1, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            check("R5 merged sources one trigger", (hits_seen - h0) == 1, 1'b1);
        end

        // sweep strobe period with mixed stimulus (R3 R4 R6 R7 R8)
        for (int per = 1; per <= 9; per++) begin
            for (int k = 0; k < 300; k++) begin
                bit v, i, p;
                v = (k % per) == 0;
                i = ($urandom_range(0, 19) == 0);
                p = ($urandom_range(0, 6) == 0) ? ~pin : pin;
                step(v, i, p);
            end
        end

        // R4: drain with strobes, nothing left pending
        for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b0);
        check("R4 nothing pending after strobes", o_held, 1'b0);
        check("R7 capture drained", o_capt, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule